// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Return Stack

This unit sits beside instruction fetch and forecasts, within the same cycle, where fetch should go next. Two tables are consulted with the current fetch address. A direct-mapped target table carries an address tag for each entry. It recognises a known branch before the instruction is decoded and supplies that branch's last taken destination. A separate, untagged table of 2-bit saturating counters, selected by low address bits, decides whether that destination is used. When neither applies, the forecast is simply the sequential address.

Training happens only when a branch actually resolves further down the pipeline. A resolve port carries the branch address, its real direction and its real destination. Every resolve trains the selected counter. Only taken outcomes write the target table. A four-deep return-address stack handles procedure returns: fetch marks call and return instructions, a call pushes its sequential address, and a return pops the stack and redirects to the popped address.

Top module: `branch_predict_unit`

## Requirements
- R1: After reset no target entry is valid, every counter holds 01 (weakly not taken) and the return stack is empty, so every lookup yields hit 0, taken 0 and next address = fetch address + 4.
- R2: The target table has 16 entries indexed by fetch_pc[5:2] with tag fetch_pc[31:6]. A lookup hits only when the indexed entry is valid and its tag matches. On a miss (and no return redirect) taken is 0 and the next address is fetch address + 4.
- R3: On a hit the prediction is taken exactly when bit 1 of the counter selected by fetch_pc[4:2] is 1. The next address is then the stored target, otherwise fetch address + 4.
- R4: A resolve moves the selected counter up by one for taken and down by one for not taken, saturating at 00 and 11, so a strongly biased counter reverses its prediction only after two opposite outcomes in a row.
- R5: The counter table has 8 entries and no tags. Branches whose addresses agree in bits [4:2] train and read the same counter, even when they occupy different target entries.
- R6: A taken resolve writes the indexed target entry (valid, tag, target), allocating on a miss and overwriting on a hit. A not-taken resolve leaves the target table unchanged but still trains the counter.
- R7: Table and stack updates take effect from the next cycle. A lookup in the same cycle as a resolve to the same entry sees the old contents.
- R8: A call pushes fetch address + 4. A return with a non-empty stack pops it and predicts taken with next address = the popped value. The hit output still reports the target-table result.
- R9: The stack holds 4 addresses. A push when full overwrites the oldest, so after five pushes, four pops return the four newest in reverse order and the stack is then empty.
- R10: A return with an empty stack leaves the stack pointer unchanged and the prediction falls back to R2/R3.
- R11: When call and return are marked in the same cycle, the return is served and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| fetch_is_call | input | 1 | Fetched instruction is a call |
| fetch_is_ret | input | 1 | Fetched instruction is a return |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch |
| res_target | input | 32 | Actual destination of the resolving branch |
| pred_hit | output | 1 | Target table holds a matching entry |
| pred_taken | output | 1 | Fetch should redirect |
| pred_next_pc | output | 32 | Predicted next fetch address |

## Verification
The bench trains one branch through all four counter states and checks that a single opposite outcome from the strong state does not flip the prediction. A design without hysteresis would flip after one outcome. It places two branches on one counter but on different target entries, which catches a tagged or wrongly indexed counter table, and it probes a different tag on an occupied entry to catch a missing tag compare. Resolve and lookup are driven to the same entry in one cycle to expose a write-through that makes a new entry visible too early. The stack is pushed past its depth, drained past empty and given call and return together: a non-wrapping stack, an underflow that moves the pointer, or a push that wins over the return would each produce wrong return addresses.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  // One training step of a 2-bit hysteresis counter.
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    if (taken) return (cur == 2'b11) ? cur : cur + 2'b01;
    else       return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction

  // Upper half of the counter range predicts taken.
  function automatic logic ctr_says_taken(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_target_table.sv
module bp_target_table #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        tgt_q[e]   <= '0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        tag_q[e]   <= wr_tag;
        tgt_q[e]   <= wr_target;
      end
    end
  end

  always_comb begin
    rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_target = tgt_q[rd_idx];
  end

endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  logic [1:0] ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ctr_q[e] <= CTR_WEAK_NT;
      else if (wr_en && (wr_idx == IDX_W'(e)))
        ctr_q[e] <= ctr_step(ctr_q[e], wr_taken);
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/bp_return_stack.sv
module bp_return_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PC_W-1:0]  push_addr,
  input  logic             pop,
  output logic [PC_W-1:0]  top_addr,
  output logic             empty,
  output logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] count
);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] top_idx;
  logic             do_pop;

  assign top_idx = ptr_q - PTR_W'(1);
  assign do_pop  = pop && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (do_pop) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (push && !pop) begin
      ptr_q <= ptr_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[s] <= '0;
      else if (push && !pop && (ptr_q == PTR_W'(s)))
        mem_q[s] <= push_addr;
    end
  end

  assign top_addr = mem_q[top_idx];
  assign empty    = (cnt_q == '0);
  assign ptr      = ptr_q;
  assign count    = cnt_q;

endmodule

// File: rtl/branch_predict_unit.sv
module branch_predict_unit
  import bp_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int TT_ENTRIES  = 16,
  parameter int DIR_ENTRIES = 8,
  parameter int RAS_DEPTH   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_is_call,
  input  logic            fetch_is_ret,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc
);

  localparam int TT_IDX_W  = $clog2(TT_ENTRIES);
  localparam int TAG_W     = PC_W - TT_IDX_W - 2;
  localparam int DIR_IDX_W = $clog2(DIR_ENTRIES);
  localparam int RS_PTR_W  = $clog2(RAS_DEPTH);
  localparam int RS_CNT_W  = $clog2(RAS_DEPTH + 1);
  localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

  // Named internal events, observed by the bound checker.
  logic                tt_hit;
  logic [PC_W-1:0]     tt_target;
  logic                tt_wr_en;
  logic [1:0]          dir_ctr;
  logic                dir_taken;
  logic                ret_used;
  logic                rs_push_en;
  logic                rs_empty;
  logic [PC_W-1:0]     rs_top;
  logic [RS_PTR_W-1:0] rs_ptr;
  logic [RS_CNT_W-1:0] rs_count;
  logic [PC_W-1:0]     seq_pc;
  logic                unused_pc_lsb;

  assign unused_pc_lsb = ^res_pc[1:0];

  assign tt_wr_en   = res_valid && res_taken;
  assign seq_pc     = fetch_pc + INSN_BYTES;
  assign rs_push_en = fetch_is_call && !fetch_is_ret;

  bp_target_table #(.PC_W(PC_W), .ENTRIES(TT_ENTRIES)) u_tt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (fetch_pc[TT_IDX_W+1:2]),
    .rd_tag    (fetch_pc[PC_W-1:TT_IDX_W+2]),
    .rd_hit    (tt_hit),
    .rd_target (tt_target),
    .wr_en     (tt_wr_en),
    .wr_idx    (res_pc[TT_IDX_W+1:2]),
    .wr_tag    (res_pc[PC_W-1:TT_IDX_W+2]),
    .wr_target (res_target)
  );

  bp_dir_table #(.ENTRIES(DIR_ENTRIES)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (fetch_pc[DIR_IDX_W+1:2]),
    .rd_ctr   (dir_ctr),
    .wr_en    (res_valid),
    .wr_idx   (res_pc[DIR_IDX_W+1:2]),
    .wr_taken (res_taken)
  );

  bp_return_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_rs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rs_push_en),
    .push_addr (seq_pc),
    .pop       (fetch_is_ret),
    .top_addr  (rs_top),
    .empty     (rs_empty),
    .ptr       (rs_ptr),
    .count     (rs_count)
  );

  assign ret_used  = fetch_is_ret && !rs_empty;
  assign dir_taken = tt_hit && ctr_says_taken(dir_ctr);

  always_comb begin
    pred_hit   = tt_hit;
    pred_taken = ret_used || dir_taken;
    if (ret_used)       pred_next_pc = rs_top;
    else if (dir_taken) pred_next_pc = tt_target;
    else                pred_next_pc = seq_pc;
  end

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W      = 32,
  parameter int RAS_DEPTH = 4,
  parameter int PTR_W     = 2,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  fetch_pc,
  input logic             fetch_is_ret,
  input logic             res_valid,
  input logic             res_taken,
  input logic             pred_hit,
  input logic             pred_taken,
  input logic [PC_W-1:0]  pred_next_pc,
  input logic             tt_wr_en,
  input logic             ret_used,
  input logic             rs_empty,
  input logic [PTR_W-1:0] rs_ptr,
  input logic [CNT_W-1:0] rs_count
);

  a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_hit && !ret_used) |-> (!pred_taken && pred_next_pc == fetch_pc + PC_W'(4)));

  a_r6_not_taken_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> !tt_wr_en);

  a_r6_taken_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |-> tt_wr_en);

  a_r8_return_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    ret_used |-> pred_taken);

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rs_count <= CNT_W'(RAS_DEPTH));

  a_r10_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_is_ret && rs_empty) |=> ($stable(rs_ptr) && rs_count == '0));

endmodule

bind branch_predict_unit bp_checker #(
  .PC_W(PC_W), .RAS_DEPTH(RAS_DEPTH), .PTR_W(RS_PTR_W), .CNT_W(RS_CNT_W)
) u_bp_checker (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_is_ret(fetch_is_ret),
  .res_valid(res_valid), .res_taken(res_taken), .pred_hit(pred_hit),
  .pred_taken(pred_taken), .pred_next_pc(pred_next_pc), .tt_wr_en(tt_wr_en),
  .ret_used(ret_used), .rs_empty(rs_empty), .rs_ptr(rs_ptr), .rs_count(rs_count)
);

// File: tb/branch_predict_unit_tb.sv
module branch_predict_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_is_call = 1'b0, fetch_is_ret = 1'b0;
  logic        res_valid = 1'b0, res_taken = 1'b0;
  logic [31:0] res_pc = '0, res_target = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_next_pc;

  int n_run = 0;
  int n_fail = 0;

  // Reference state, built from the requirements.
  bit          m_valid [16];
  logic [25:0] m_tag   [16];
  logic [31:0] m_tgt   [16];
  int          m_ctr   [8];
  logic [31:0] s_mem   [4];
  int          s_ptr, s_cnt;

  always #4 clk = ~clk;

  branch_predict_unit dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_is_call(fetch_is_call),
    .fetch_is_ret(fetch_is_ret), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sat_move(input int c, input bit up);
    int n;
    n = up ? c + 1 : c - 1;
    if (n > 3) n = 3;
    if (n < 0) n = 0;
    return n;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    for (int i = 0; i < 8; i++) m_ctr[i] = 1;
    for (int i = 0; i < 4; i++) s_mem[i] = '0;
    s_ptr = 0; s_cnt = 0;
  endtask

  task automatic step(input logic [31:0] pc, input bit call, input bit ret,
                      input bit rv, input logic [31:0] rpc, input bit rt,
                      input logic [31:0] rtgt, input string tag);
    int ti, di;
    bit hit, dtk, rused;
    logic [31:0] e_next;
    @(negedge clk);
    fetch_pc = pc; fetch_is_call = call; fetch_is_ret = ret;
    res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtgt;
    #1;
    ti = int'(pc[5:2]); di = int'(pc[4:2]);
    hit   = m_valid[ti] && (m_tag[ti] == pc[31:6]);
    dtk   = hit && (m_ctr[di] >= 2);
    rused = ret && (s_cnt > 0);
    if (rused)    e_next = s_mem[(s_ptr + 3) % 4];
    else if (dtk) e_next = m_tgt[ti];
    else          e_next = pc + 32'd4;
    chk(tag, "hit", {31'd0, pred_hit}, {31'd0, hit});
    chk(tag, "taken", {31'd0, pred_taken}, {31'd0, rused || dtk});
    chk(tag, "next_pc", pred_next_pc, e_next);
    // Advance reference state as of the coming edge.
    if (rv) begin
      m_ctr[int'(rpc[4:2])] = sat_move(m_ctr[int'(rpc[4:2])], rt);
      if (rt) begin
        m_valid[int'(rpc[5:2])] = 1;
        m_tag[int'(rpc[5:2])]   = rpc[31:6];
        m_tgt[int'(rpc[5:2])]   = rtgt;
      end
    end
    if (ret) begin
      if (s_cnt > 0) begin s_ptr = (s_ptr + 3) % 4; s_cnt--; end
    end else if (call) begin
      s_mem[s_ptr] = pc + 32'd4;
      s_ptr = (s_ptr + 1) % 4;
      if (s_cnt < 4) s_cnt++;
    end
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    step(pc, 0, 0, 0, '0, 0, '0, tag);
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] rpc, input bit rt,
                       input logic [31:0] rtgt, input string tag);
    step(pc, 0, 0, 1, rpc, rt, rtgt, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pc2;
    pa  = 32'h0001_0010;   // target index 4, counter index 4
    pb  = 32'h0001_0030;   // target index 12, counter index 4 (alias)
    pc2 = 32'h0002_0010;   // target index 4, different tag
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: clean state after reset
    look(pa, "R1"); look(pc2, "R1"); look(32'h0000_0ffc, "R1");
    // R6: not-taken resolve installs nothing, but trains the counter (01 -> 00)
    train(pa, pa, 0, 32'h0, "R6"); look(pa, "R6");
    // R7: same-cycle resolve and lookup sees the old (empty) entry
    train(pa, pa, 1, 32'h0000_0400, "R7");
    // R3: hit with counter 01 predicts not taken
    look(pa, "R3");
    // R2: other tag on same entry misses
    look(pc2, "R2");
    // R3/R4: climb to taken, then to strong taken
    train(pa, pa, 1, 32'h0000_0400, "R3"); look(pa, "R3");
    train(pa, pa, 1, 32'h0000_0400, "R4");
    train(pa, pa, 0, 32'h0000_0400, "R4"); look(pa, "R4");
    train(pa, pa, 0, 32'h0000_0400, "R4"); look(pa, "R4");
    // R5: aliasing branch shares counter index 4 (01 -> 10)
    train(pb, pb, 1, 32'h0000_0800, "R5");
    look(pa, "R5"); look(pb, "R5");
    // R6: taken resolve overwrites the destination of a hitting entry
    train(pa, pa, 1, 32'h0000_0900, "R6"); look(pa, "R6");
    // R8/R9: five calls overflow the 4-deep stack
    for (int k = 1; k <= 5; k++) step(32'h0000_0100 * k, 1, 0, 0, '0, 0, '0, "R9");
    for (int k = 0; k < 4; k++) step(32'h0000_1000, 0, 1, 0, '0, 0, '0, "R8");
    // R10: return on empty stack falls back to the tables
    step(32'h0000_1000, 0, 1, 0, '0, 0, '0, "R10");
    step(pa, 0, 1, 0, '0, 0, '0, "R10");
    // R11: call and return together; return wins, no push
    step(32'h0000_2000, 1, 0, 0, '0, 0, '0, "R11");
    step(32'h0000_3000, 1, 1, 0, '0, 0, '0, "R11");
    step(32'h0000_4000, 0, 1, 0, '0, 0, '0, "R11");

    // Constrained random phase covering R2, R3, R4, R5, R6, R8
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] fp, rp, rg;
      bit c, r, v, t;
      fp = ($urandom_range(0, 1) ? 32'h0001_0000 : 32'h0002_0000) | (32'($urandom_range(0, 15)) << 2);
      rp = ($urandom_range(0, 1) ? 32'h0001_0000 : 32'h0002_0000) | (32'($urandom_range(0, 15)) << 2);
      rg = $urandom() & 32'hffff_fffc;
      c = ($urandom_range(0, 7) == 0);
      r = ($urandom_range(0, 7) == 0);
      v = $urandom_range(0, 1);
      t = $urandom_range(0, 1);
      step(fp, c, r, v, rp, t, rg, "R2_R3_rand");
    end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule